// File: doc/BRIEF.md
# Compressed Branch Target Generator

This block computes the destination of a direct branch when the instruction stream is stored compressed. Compressed instructions start at arbitrary bit positions, so an address has two parts: a 30-bit word address and a 4-bit pointer that picks the bit inside that 32-bit word. The displacement carried by the branch is split in the same way. Its lowest four bits are a bit pointer, and the bits above them form a signed word displacement.

The caller presents the branch class (unconditional with a 24-bit field, or conditional with a 14-bit field), the addressing mode (absolute or relative), the raw displacement and the compressed address of the branch. In absolute mode, the target word is the sign-extended word displacement. In relative mode, it is the branch's own word address plus that value, wrapping modulo 2^30. The bit pointer of the field becomes the target's pointer unchanged. The result is registered and presented for one cycle with a valid strobe.

Top module: `cbr_target_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `out_addr` become zero on that edge.
- R2: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low in the cycle after each cycle in which `in_valid` is low.
- R3: `out_addr[3:0]` equals `in_disp[3:0]` of the accepted input, taken unchanged and not added to anything.
- R4: For an unconditional absolute branch (`in_is_cond`=0, `in_is_abs`=1), `out_addr[33:4]` is `in_disp[23:4]` sign-extended from bit 23 to 30 bits.
- R5: For a conditional absolute branch (`in_is_cond`=1, `in_is_abs`=1), `out_addr[33:4]` is `in_disp[13:4]` sign-extended from bit 13, and `in_disp[23:14]` has no effect.
- R6: In relative mode (`in_is_abs`=0), `out_addr[33:4]` is `in_addr[33:4]` plus the sign-extended word displacement of the class (as in R4 or R5).
- R7: The relative sum wraps modulo 2^30 in both directions, with no flag.
- R8: While `in_valid` is low, `out_addr` keeps its last value whatever the other inputs do.
- R9: The branch's own bit pointer `in_addr[3:0]` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inputs are sampled this cycle |
| in_is_cond | input | 1 | 1 = conditional branch (14-bit field), 0 = unconditional (24-bit field) |
| in_is_abs | input | 1 | 1 = absolute mode, 0 = relative mode |
| in_disp | input | 24 | Raw displacement field, right aligned |
| in_addr | input | 34 | Compressed address of the branch: {word[29:0], bit pointer[3:0]} |
| out_valid | output | 1 | Target valid, one cycle per accepted input |
| out_addr | output | 34 | Compressed target: {word[29:0], bit pointer[3:0]} |

## Verification
Two things can happen in the same cycle: a new branch is captured while the previous target is still being presented. The stimulus table is driven back to back, with `in_valid` held high across every entry. Each cycle must therefore show `out_valid` still high and `out_addr` already replaced by the next entry's target, with no gap and no stale value. Reset is also applied while a target is presented, and the register must clear in place of the capture.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    localparam int PTR_W   = 4;
    localparam int WORD_W  = 30;
    localparam int ADDR_W  = WORD_W + PTR_W;
    localparam int UNC_FW  = 24;
    localparam int CND_FW  = 14;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } cbr_state_t;
endpackage

// File: rtl/cbr_disp_split.sv
module cbr_disp_split #(
    parameter int FIELD_W = 24,
    parameter int PTR_W   = 4,
    parameter int UNC_W   = 24,
    parameter int CND_W   = 14,
    parameter int WORD_W  = 30
) (
    input  logic [FIELD_W-1:0] disp,
    input  logic               is_cond,
    output logic [PTR_W-1:0]   ptr,
    output logic [WORD_W-1:0]  word_off
);
    localparam int UNC_DW = UNC_W - PTR_W;
    localparam int CND_DW = CND_W - PTR_W;

    logic [UNC_DW-1:0] unc_raw;
    logic [CND_DW-1:0] cnd_raw;
    logic [WORD_W-1:0] unc_ext;
    logic [WORD_W-1:0] cnd_ext;

    assign ptr     = disp[PTR_W-1:0];
    assign unc_raw = disp[UNC_W-1:PTR_W];
    assign cnd_raw = disp[CND_W-1:PTR_W];

    // sign extension of each word displacement to the word width
    assign unc_ext = {{(WORD_W-UNC_DW){unc_raw[UNC_DW-1]}}, unc_raw};
    assign cnd_ext = {{(WORD_W-CND_DW){cnd_raw[CND_DW-1]}}, cnd_raw};

    assign word_off = is_cond ? cnd_ext : unc_ext;
endmodule

// File: rtl/cbr_word_calc.sv
module cbr_word_calc #(
    parameter int WORD_W = 30
) (
    input  logic [WORD_W-1:0] base_word,
    input  logic [WORD_W-1:0] word_off,
    input  logic              is_abs,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sum;

    // modulo 2^WORD_W: carry out is dropped
    assign sum  = base_word + word_off;
    assign word = is_abs ? word_off : sum;
endmodule

// File: rtl/cbr_target_gen.sv
module cbr_target_gen
    import cbr_pkg::*;
#(
    parameter int P_PTR_W  = PTR_W,
    parameter int P_WORD_W = WORD_W,
    parameter int P_UNC_FW = UNC_FW,
    parameter int P_CND_FW = CND_FW,
    localparam int P_ADDR_W = P_WORD_W + P_PTR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_is_cond,
    input  logic                in_is_abs,
    input  logic [P_UNC_FW-1:0] in_disp,
    input  logic [P_ADDR_W-1:0] in_addr,
    output logic                out_valid,
    output logic [P_ADDR_W-1:0] out_addr
);
    cbr_state_t st_d, st_q;

    logic [P_PTR_W-1:0]  tgt_ptr;
    logic [P_WORD_W-1:0] tgt_off;
    logic [P_WORD_W-1:0] tgt_word;
    logic                unused_branch_ptr;

    // the branch's own bit pointer never enters the arithmetic
    assign unused_branch_ptr = ^in_addr[P_PTR_W-1:0];

    cbr_disp_split #(
        .FIELD_W (P_UNC_FW),
        .PTR_W   (P_PTR_W),
        .UNC_W   (P_UNC_FW),
        .CND_W   (P_CND_FW),
        .WORD_W  (P_WORD_W)
    ) u_split (
        .disp     (in_disp),
        .is_cond  (in_is_cond),
        .ptr      (tgt_ptr),
        .word_off (tgt_off)
    );

    cbr_word_calc #(
        .WORD_W (P_WORD_W)
    ) u_calc (
        .base_word (in_addr[P_ADDR_W-1:P_PTR_W]),
        .word_off  (tgt_off),
        .is_abs    (in_is_abs),
        .word      (tgt_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.addr = {tgt_word, tgt_ptr};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_addr  = st_q.addr;
endmodule

// File: rtl/cbr_target_chk.sv
module cbr_target_chk #(
    parameter int PTR_W  = 4,
    parameter int WORD_W = 30,
    parameter int UNC_W  = 24,
    parameter int CND_W  = 14,
    localparam int ADDR_W = WORD_W + PTR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_is_cond,
    input logic              in_is_abs,
    input logic [UNC_W-1:0]  in_disp,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr
);
    logic [WORD_W-1:0] ref_unc;
    logic [WORD_W-1:0] ref_cnd;
    logic [WORD_W-1:0] ref_off;
    logic [WORD_W-1:0] ref_rel;

    assign ref_unc = WORD_W'(signed'(in_disp[UNC_W-1:PTR_W]));
    assign ref_cnd = WORD_W'(signed'(in_disp[CND_W-1:PTR_W]));
    assign ref_off = in_is_cond ? ref_cnd : ref_unc;
    assign ref_rel = WORD_W'(in_addr[ADDR_W-1:PTR_W] + ref_off);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_addr == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    ptr_copy_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_addr[PTR_W-1:0] == $past(in_disp[PTR_W-1:0]));

    // R4
    unc_abs_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_abs && !in_is_cond) |=>
            out_addr[ADDR_W-1:PTR_W] == $past(ref_unc));

    // R5
    cnd_abs_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_abs && in_is_cond) |=>
            out_addr[ADDR_W-1:PTR_W] == $past(ref_cnd));

    // R6
    rel_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_is_abs) |=>
            out_addr[ADDR_W-1:PTR_W] == $past(ref_rel));

    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_addr));
endmodule

bind cbr_target_gen cbr_target_chk #(
    .PTR_W  (P_PTR_W),
    .WORD_W (P_WORD_W),
    .UNC_W  (P_UNC_FW),
    .CND_W  (P_CND_FW)
) u_target_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_is_cond (in_is_cond),
    .in_is_abs  (in_is_abs),
    .in_disp    (in_disp),
    .in_addr    (in_addr),
    .out_valid  (out_valid),
    .out_addr   (out_addr)
);

// File: tb/cbr_target_gen_bench.sv
module cbr_target_gen_bench;
    localparam int NVEC = 12;
    // {is_cond, is_abs, disp[23:0], addr[33:0], expected[33:0]}
    localparam logic [93:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 24'h000125, 34'h012345678, 34'h000000125},  // R4 positive
        {1'b0, 1'b1, 24'hFFFFF3, 34'h000000000, 34'h3FFFFFFF3},  // R4 negative
        {1'b1, 1'b1, 24'hABC7F9, 34'h000000000, 34'h0000007F9},  // R5 upper bits ignored
        {1'b1, 1'b1, 24'h002205, 34'h000000000, 34'h3FFFFE205},  // R5 negative
        {1'b0, 1'b0, 24'h000107, 34'h000001004, 34'h000001107},  // R6 forward
        {1'b0, 1'b0, 24'hFFFF0C, 34'h00000500A, 34'h000004F0C},  // R6 backward
        {1'b1, 1'b0, 24'h003FF2, 34'h000000ABF, 34'h000000AA2},  // R6 conditional back
        {1'b1, 1'b0, 24'hFFC1F0, 34'h000002000, 34'h0000021F0},  // R6 cond, upper ignored
        {1'b0, 1'b0, 24'h000026, 34'h3FFFFFFF1, 34'h000000016},  // R7 wrap up
        {1'b0, 1'b0, 24'hFFFFEF, 34'h000000000, 34'h3FFFFFFEF},  // R7 wrap down
        {1'b0, 1'b1, 24'h7FFFF8, 34'h000000000, 34'h0007FFFF8},  // R4 max positive
        {1'b0, 1'b1, 24'h800000, 34'h000000000, 34'h3FF800000}   // R4 most negative
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_is_cond = 1'b0;
    logic        in_is_abs = 1'b0;
    logic [23:0] in_disp = '0;
    logic [33:0] in_addr = '0;
    logic        out_valid;
    logic [33:0] out_addr;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    cbr_target_gen u_cbr_target_gen (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_is_cond (in_is_cond),
        .in_is_abs  (in_is_abs),
        .in_disp    (in_disp),
        .in_addr    (in_addr),
        .out_valid  (out_valid),
        .out_addr   (out_addr)
    );

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [93:0] v);
        in_valid   = 1'b1;
        in_is_cond = v[93];
        in_is_abs  = v[92];
        in_disp    = v[91:68];
        in_addr    = v[67:34];
    endtask

    initial begin
        #(20 * 5000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", 34'(out_valid), 34'h0);
        check("R1 addr", out_addr, 34'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 idle", 34'(out_valid), 34'h0);

        // back-to-back table walk: capture and present in the same cycle
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check("R2 valid", 34'(out_valid), 34'h1);
            check("R3-R7 target", out_addr, VEC[i][33:0]);
            check("R3 pointer", 34'(out_addr[3:0]), 34'(VEC[i][71:68]));
        end

        // R8: hold while idle, inputs moving
        in_valid   = 1'b0;
        in_disp    = 24'h123456;
        in_addr    = 34'h0ABCDEF01;
        in_is_abs  = 1'b1;
        @(negedge clk);
        check("R2 drop", 34'(out_valid), 34'h0);
        check("R8 hold", out_addr, VEC[NVEC-1][33:0]);
        in_disp = 24'h000001;
        @(negedge clk);
        check("R8 hold again", out_addr, VEC[NVEC-1][33:0]);

        // R9: branch pointer bits differ, same result as forward relative entry
        drive({1'b0, 1'b0, 24'h000107, 34'h00000100F, 34'h0});
        @(negedge clk);
        check("R9 own pointer", out_addr, 34'h000001107);
        drive({1'b0, 1'b0, 24'h000107, 34'h000001000, 34'h0});
        @(negedge clk);
        check("R9 own pointer zero", out_addr, 34'h000001107);

        // R1: reset wins over a capture in the same cycle
        drive(VEC[1]);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid valid", 34'(out_valid), 34'h0);
        check("R1 mid addr", out_addr, 34'h0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 after reset", 34'(out_valid), 34'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule